// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter with a serial port. It works in one system clock domain and oversamples the port: an active-low chip select, a serial clock and a serial data input. While selected, it hunts for a start bit and shifts in a four-bit channel address. It decodes that address into one-hot positive-input and negative-input selects. It then runs a binary search driven by a one-bit comparator result, and presents an 8-bit trial code to the external DAC model.

Each decision is driven on the serial data output at the serial-clock falling edge on which it is made, MSB first. The result is then replayed LSB first. A busy status marks the conversion window. It rises half a serial clock after the last address bit and falls half a serial clock after the last decision. Both outputs carry enables that are low while the block is deselected, so a pad can tri-state them. A parameter selects a fixed-input variant. This variant needs no address, converts channel 0 against channel 1, and has no replay.

Top module: `sar_seq`

## Requirements
- R1: While chip select (cs_ni) is high, the sequencer is cleared. This holds even in the middle of a conversion: sdo_oe_o, busy_o, busy_oe_o, trial_o and both selects read zero.
- R2: Zeros on sdi_i before the first 1 are discarded. The first 1 sampled at a serial-clock rise is the start bit.
- R3: The four bits after the start bit are, in order: mode (1 = single-ended), odd/sign, pair, and a spare bit that has no effect. Let ch = 2*pair + odd. Single-ended mode gives pos_sel_o = 1<<ch, neg_sel_o = 0 and neg_com_o = 1. Differential mode gives pos_sel_o = 1<<ch and neg_sel_o = 1<<(2*pair + !odd).
- R4: At the serial-clock fall that follows the rise capturing the spare bit, busy_o goes high and sdo_oe_o goes high with sdo_o = 0. This leading zero holds for one serial period.
- R5: On each of the next 8 falls, sdo_o shows one decision, MSB first. cmp_i = 1 keeps the trial bit. The final trial_o equals the result.
- R6: busy_o stays high through the 8th decision. It falls at the next serial-clock rise.
- R7: The next 7 falls after the 8th decision drive result bits 1 to 7. The fall after that drops sdo_oe_o, even if clocking continues.
- R8: After the start bit, sdi_i has no effect until chip select is raised again. Further clocks neither change the selects nor start another conversion.
- R9: With FIXED_IN = 1, the first rise after select starts the conversion, with channel 0 positive and channel 1 negative. sdo_oe_o drops at the fall after bit 0.
- R10: If the negative input exceeds the positive input, the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in (start bit and address) |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| trial_o | output | RES_W | Trial code to DAC |
| pos_sel_o | output | 4 | One-hot positive input select |
| neg_sel_o | output | 4 | One-hot negative input select |
| neg_com_o | output | 1 | Negative input tied to common |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| busy_o | output | 1 | Conversion in progress |
| busy_oe_o | output | 1 | Drive enable for busy_o |

## Verification
The hardest case to reach is an abort in the middle of a search. Chip select must rise after the trial code has partly settled. The next conversion must then start clean from a new start bit, with no leftover result bits or address. The bench gets there with a task that stops clocking after three decisions and raises select. It checks the cleared outputs, then runs a full conversion. A second instance with the fixed-input parameter covers the variant with no address phase.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int N_CH   = 4;
  localparam int ADDR_N = 4;

  typedef enum logic [2:0] {
    ST_HUNT, ST_ADDR, ST_SAMPLE, ST_CONV, ST_REPLAY, ST_TAIL, ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic single;
    logic odd;
    logic pair;
    logic spare;
  } mux_addr_t;
endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_o,
  output logic sdi_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] cs_s, ck_s, di_s;
  logic ck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s <= '1;
      ck_s <= '0;
      di_s <= '0;
      ck_d <= 1'b0;
    end else begin
      cs_s <= {cs_s[STAGES-2:0], cs_ni};
      ck_s <= {ck_s[STAGES-2:0], sclk_i};
      di_s <= {di_s[STAGES-2:0], sdi_i};
      ck_d <= ck_s[STAGES-1];
    end
  end

  assign cs_o   = cs_s[STAGES-1];
  assign sdi_o  = di_s[STAGES-1];
  assign rise_o = ck_s[STAGES-1] & ~ck_d;
  assign fall_o = ~ck_s[STAGES-1] & ck_d;
endmodule

// File: rtl/sar_seq_decode.sv
module sar_seq_decode
  import sar_seq_pkg::*;
#(
  parameter bit FIXED_IN = 1'b0
) (
  input  mux_addr_t         addr_i,
  input  logic              vld_i,
  output logic [N_CH-1:0]   pos_o,
  output logic [N_CH-1:0]   neg_o,
  output logic              com_o
);
  always_comb begin
    pos_o = '0;
    neg_o = '0;
    com_o = 1'b0;
    if (vld_i) begin
      if (FIXED_IN) begin
        pos_o[0] = 1'b1;
        neg_o[1] = 1'b1;
      end else begin
        pos_o[{addr_i.pair, addr_i.odd}] = 1'b1;
        if (addr_i.single) com_o = 1'b1;
        else neg_o[{addr_i.pair, ~addr_i.odd}] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq_step.sv
module sar_seq_step #(
  parameter int RES_W = 8,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] res_o,
  output logic [RES_W-1:0] trial_o
);
  for (genvar g = 0; g < RES_W; g++) begin : g_bit
    assign res_o[g]   = (int'(idx_i) == g) ? cmp_i : res_i[g];
    // next guess: set the bit just below the one decided
    assign trial_o[g] = res_o[g] | (int'(idx_i) == g + 1);
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit FIXED_IN    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [N_CH-1:0]  pos_sel_o,
  output logic [N_CH-1:0]  neg_sel_o,
  output logic             neg_com_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o,
  output logic             busy_oe_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic cs_q, sdi_q, sclk_rise, sclk_fall;
  seq_st_e st_q;
  logic [IDX_W-1:0] cnt_q;
  mux_addr_t addr_q;
  logic vld_q, sdo_q, oe_q, busy_q;
  logic [RES_W-1:0] res_q, trial_q, res_nxt, trial_nxt;

  sar_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i,
    .cs_o(cs_q), .sdi_o(sdi_q), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sar_seq_decode #(.FIXED_IN(FIXED_IN)) u_dec (
    .addr_i(addr_q), .vld_i(vld_q),
    .pos_o(pos_sel_o), .neg_o(neg_sel_o), .com_o(neg_com_o)
  );

  sar_seq_step #(.RES_W(RES_W)) u_step (
    .res_i(res_q), .idx_i(cnt_q), .cmp_i,
    .res_o(res_nxt), .trial_o(trial_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT; cnt_q <= '0; addr_q <= '0; vld_q <= 1'b0;
      res_q <= '0; trial_q <= '0; sdo_q <= 1'b0; oe_q <= 1'b0; busy_q <= 1'b0;
    end else if (cs_q) begin
      st_q <= ST_HUNT; cnt_q <= '0; addr_q <= '0; vld_q <= 1'b0;
      res_q <= '0; trial_q <= '0; sdo_q <= 1'b0; oe_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_HUNT: if (sclk_rise) begin
          if (FIXED_IN) begin
            st_q  <= ST_SAMPLE;
            vld_q <= 1'b1;
          end else if (sdi_q) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end
        end
        ST_ADDR: if (sclk_rise) begin
          addr_q <= mux_addr_t'({addr_q[ADDR_N-2:0], sdi_q});
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == IDX_W'(ADDR_N - 1)) begin
            st_q  <= ST_SAMPLE;
            vld_q <= 1'b1;
          end
        end
        ST_SAMPLE: if (sclk_fall) begin
          busy_q  <= 1'b1;
          oe_q    <= 1'b1;
          sdo_q   <= 1'b0;
          res_q   <= '0;
          trial_q <= RES_W'(1) << (RES_W - 1);
          cnt_q   <= IDX_W'(RES_W - 1);
          st_q    <= ST_CONV;
        end
        ST_CONV: if (sclk_fall) begin
          sdo_q   <= cmp_i;
          res_q   <= res_nxt;
          trial_q <= trial_nxt;
          if (cnt_q == '0) begin
            st_q  <= FIXED_IN ? ST_TAIL : ST_REPLAY;
            cnt_q <= IDX_W'(1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_REPLAY: begin
          if (sclk_rise) busy_q <= 1'b0;
          if (sclk_fall) begin
            sdo_q <= res_q[cnt_q];
            if (cnt_q == IDX_W'(RES_W - 1)) st_q <= ST_TAIL;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (sclk_rise) busy_q <= 1'b0;
          if (sclk_fall) begin
            oe_q  <= 1'b0;
            sdo_q <= 1'b0;
            st_q  <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign trial_o   = trial_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
  assign busy_o    = busy_q;
  assign busy_oe_o = ~cs_q;

  // R1
  cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> (!oe_q && !busy_q && !vld_q && trial_q == '0));

  // R4
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (oe_q && !sdo_q && $past(sclk_fall)));

  // R6
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(sclk_rise) || $past(cs_q)));

  // R3
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(pos_sel_o) && $onehot0(neg_sel_o) && (pos_sel_o & neg_sel_o) == '0));

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !cs_q) |=> $stable(addr_q));

  // R5
  trial_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trial_q) |-> ($past(sclk_fall) || $past(cs_q)));
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cs_fix_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] chv [4];

  logic [7:0] trial, f_trial;
  logic [3:0] pos, neg, f_pos, f_neg;
  logic com, sdo, oe, busy, boe, f_com, f_sdo, f_oe, f_busy, f_boe;
  logic cmp, f_cmp;

  int checks = 0, errors = 0;
  logic hi_busy, lo_sdo, lo_oe, lo_busy, hi_fbusy, lo_fsdo, lo_foe, lo_fbusy;

  always #2 clk = ~clk;

  function automatic logic cmp_model(input logic [3:0] p, input logic [3:0] n,
                                     input logic c, input logic [7:0] t);
    int pv = 0, nv = 0;
    for (int i = 0; i < 4; i++) begin
      if (p[i]) pv = int'(chv[i]);
      if (n[i] && !c) nv = int'(chv[i]);
    end
    return ((pv > nv) ? pv - nv : 0) >= int'(t);
  endfunction

  assign cmp   = cmp_model(pos, neg, com, trial);
  assign f_cmp = cmp_model(f_pos, f_neg, f_com, f_trial);

  sar_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi), .cmp_i(cmp),
    .trial_o(trial), .pos_sel_o(pos), .neg_sel_o(neg), .neg_com_o(com),
    .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy), .busy_oe_o(boe)
  );

  sar_seq #(.FIXED_IN(1'b1)) dut_fix (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_fix_n), .sclk_i(sclk), .sdi_i(sdi), .cmp_i(f_cmp),
    .trial_o(f_trial), .pos_sel_o(f_pos), .neg_sel_o(f_neg), .neg_com_o(f_com),
    .sdo_o(f_sdo), .sdo_oe_o(f_oe), .busy_o(f_busy), .busy_oe_o(f_boe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    sdi = d; sclk = 1'b1; wait_clk(8);
    hi_busy = busy; hi_fbusy = f_busy;
    sclk = 1'b0; wait_clk(8);
    lo_sdo = sdo; lo_oe = oe; lo_busy = busy;
    lo_fsdo = f_sdo; lo_foe = f_oe; lo_fbusy = f_busy;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " sdo_oe"}, int'(oe), 0);
    chk({tag, " busy_oe"}, int'(boe), 0);
    chk({tag, " busy"}, int'(busy), 0);
    chk({tag, " trial"}, int'(trial), 0);
    chk({tag, " pos"}, int'(pos), 0);
  endtask

  task automatic run_conv(input int zeros, input logic sgl, input logic odd,
                          input logic pair, input logic spare);
    int pc = 2 * int'(pair) + int'(odd);
    int nc = 2 * int'(pair) + int'(!odd);
    int pv = int'(chv[pc]);
    int nv = sgl ? 0 : int'(chv[nc]);
    logic [7:0] exp = 8'((pv > nv) ? pv - nv : 0);
    logic [3:0] keep;
    cs_n = 1'b0; wait_clk(8);
    for (int i = 0; i < zeros; i++) pulse(1'b0);
    chk("R2 hunting sdo_oe", int'(lo_oe), 0);
    pulse(1'b1); pulse(sgl); pulse(odd); pulse(pair);
    chk("R4 busy before last addr bit", int'(lo_busy), 0);
    pulse(spare);
    chk("R4 busy low at capture rise", int'(hi_busy), 0);
    chk("R4 busy high", int'(lo_busy), 1);
    chk("R4 sdo_oe", int'(lo_oe), 1);
    chk("R4 leading zero", int'(lo_sdo), 0);
    chk("R3 pos_sel", int'(pos), 1 << pc);
    chk("R3 neg_sel", int'(neg), sgl ? 0 : (1 << nc));
    chk("R3 neg_com", int'(com), int'(sgl));
    keep = pos;
    for (int k = 0; k < 8; k++) begin
      pulse(1'(k));  // R8: junk on sdi during search
      chk("R5 msb-first bit", int'(lo_sdo), int'(exp[7-k]));
      chk("R6 busy during search", int'(lo_busy), 1);
    end
    chk("R5 final trial", int'(trial), int'(exp));
    for (int k = 1; k < 8; k++) begin
      pulse(1'b0);
      if (k == 1) chk("R6 busy fall", int'(hi_busy), 0);
      chk("R7 lsb-first bit", int'(lo_sdo), int'(exp[k]));
      chk("R7 sdo_oe during replay", int'(lo_oe), 1);
    end
    pulse(1'b0);
    chk("R7 sdo_oe off after replay", int'(lo_oe), 0);
    for (int k = 0; k < 3; k++) pulse(1'b1);
    chk("R8 no restart sdo_oe", int'(lo_oe), 0);
    chk("R8 no restart busy", int'(lo_busy), 0);
    chk("R8 selects held", int'(pos), int'(keep));
    cs_n = 1'b1; wait_clk(8);
    check_idle("R1 after deselect");
  endtask

  task automatic run_abort();
    cs_n = 1'b0; wait_clk(8);
    pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b0); pulse(1'b0);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    chk("R4 busy before abort", int'(lo_busy), 1);
    cs_n = 1'b1; wait_clk(8);
    check_idle("R1 abort");
  endtask

  task automatic run_fixed();
    logic [7:0] exp = 8'((chv[0] > chv[1]) ? chv[0] - chv[1] : 0);
    cs_fix_n = 1'b0; wait_clk(8);
    pulse(1'b0);
    chk("R9 busy on first fall", int'(lo_fbusy), 1);
    chk("R9 leading zero", int'(lo_fsdo), 0);
    chk("R9 pos ch0", int'(f_pos), 1);
    chk("R9 neg ch1", int'(f_neg), 2);
    for (int k = 0; k < 8; k++) begin
      pulse(1'b1);
      chk("R9 msb-first bit", int'(lo_fsdo), int'(exp[7-k]));
    end
    pulse(1'b0);
    chk("R9 busy fall", int'(hi_fbusy), 0);
    chk("R9 no replay sdo_oe", int'(lo_foe), 0);
    cs_fix_n = 1'b1; wait_clk(8);
    chk("R1 fixed sdo_oe", int'(f_oe), 0);
  endtask

  initial begin
    chv[0] = 8'hA5; chv[1] = 8'h00; chv[2] = 8'h00; chv[3] = 8'h3C;
    wait_clk(4);
    check_idle("R1 reset");
    rst_n = 1'b1; wait_clk(4);
    check_idle("R1 idle");
    run_conv(0, 1'b1, 1'b0, 1'b0, 1'b0);  // single ch0
    run_conv(3, 1'b1, 1'b1, 1'b1, 1'b1);  // R2: leading zeros, single ch3
    chv[2] = 8'hF0; chv[3] = 8'h21;
    run_conv(1, 1'b0, 1'b0, 1'b1, 1'b0);  // diff ch2+ ch3-
    chv[0] = 8'h80; chv[1] = 8'h40;
    run_conv(2, 1'b0, 1'b1, 1'b0, 1'b1);  // R10: ch1+ < ch0-
    chv[2] = 8'hFF;
    run_conv(0, 1'b1, 1'b0, 1'b1, 1'b1);  // full scale
    run_abort();
    chv[1] = 8'h00;
    run_conv(1, 1'b0, 1'b0, 1'b0, 1'b0);  // clean after abort
    chv[0] = 8'h9A; chv[1] = 8'h1B;
    run_fixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule